// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer with Fault Classification

This block translates instruction and data virtual addresses through a small, fully associative table of page-pair entries. Each entry covers two neighbouring 4 KB pages. It holds a tag (the virtual page number with its lowest bit dropped), an address-space identifier, a global flag, and, for each half, a frame number with its own valid and dirty bits. A single write port loads a whole entry at a time.

Each request carries a virtual address, the current address-space identifier, an access kind (fetch, load or store) and an alignment verdict computed upstream. After one clock edge the block returns one of two results. On success it returns the physical address. On failure it returns a fault code with a fixed priority. For every fault it also returns the faulting address. For translation faults it also returns precomputed fields that a handler writes into its entry-high and context registers.

Top module: `tlbx_top`

## Requirements
- R1: Every cycle with `req_valid` high is followed, one clock edge later, by `rsp_valid` high with the result of that request. `rsp_valid` is low in the cycle after a cycle without a request.
- R2: A request with `req_misalign` high faults with an address error, and this outranks every other fault. The code is 2 when `req_kind` is 2 (store). It is 1 for fetch (0), load (1) and the unused kind 3.
- R3: An aligned request that matches no entry reports a refill fault, code 3.
- R4: An entry matches when its tag equals virtual address bits [31:13] and either its global flag is set or its identifier equals `req_asid`.
- R5: Virtual address bit 12 selects the odd (1) or even (0) half of the matching entry. If that half's valid bit is clear, the request reports an invalid fault, code 4.
- R6: A store that hits a valid half with its dirty bit clear reports a modification fault, code 5. Fetches and loads ignore the dirty bit.
- R7: A request that does not fault reports code 0, with `rsp_pa` equal to the half's frame number joined with virtual address bits [11:0].
- R8: On any fault, `rsp_badvaddr` equals the request address, and `rsp_pa` is 0. Without a fault, `rsp_badvaddr` is 0.
- R9: On codes 3, 4 and 5, the fill outputs take these values:
  - `rsp_hi_vpn2` and `rsp_ctx_badvpn2` equal the virtual page number (address bits [31:12]) shifted right by 2.
  - `rsp_hi_vpn2x` equals its low two bits.
  - `rsp_hi_asid` equals `req_asid`.
  
  On other codes, all four fill outputs are 0.
- R10: When a write is applied at a clock edge, a request presented in the following cycle sees the new entry. After reset, every entry has tag 0, identifier 0, global clear and both halves invalid.
- R11: When several entries match, the lowest-numbered entry decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | IDX_W | Entry number to load |
| wr_tag | input | TAG_W | Page-pair tag (address bits [31:13]) |
| wr_asid | input | ASID_W | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_pfn_even | input | PFN_W | Frame number of the even half |
| wr_valid_even | input | 1 | Even half valid |
| wr_dirty_even | input | 1 | Even half writable |
| wr_pfn_odd | input | PFN_W | Frame number of the odd half |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_dirty_odd | input | 1 | Odd half writable |
| req_valid | input | 1 | Translation request present |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Current address-space identifier |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_misalign | input | 1 | Upstream alignment check failed |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 3 | Fault code, 0 when none |
| rsp_pa | output | PA_W | Physical address |
| rsp_badvaddr | output | VA_W | Faulting address |
| rsp_hi_vpn2 | output | FILL_W | Page number shifted right by 2 |
| rsp_hi_vpn2x | output | 2 | Low two page-number bits |
| rsp_hi_asid | output | ASID_W | Identifier for the entry-high fill |
| rsp_ctx_badvpn2 | output | FILL_W | Page number shifted right by 2, for the context fill |

## Verification
The assertions assume three things about the inputs:
- `req_kind` uses only the fetch, load and store codes.
- The alignment verdict arrives in the same cycle as the address.
- The properties that reach back one cycle through `$past` rely on the request fields being sampled at the edge that registers them.

The stimulus drives every input on the falling edge, so no field changes at the registering edge. It issues only kinds 0 to 2 and never places a write and a request for the same entry in one cycle. The sweeps walk every page of a small window, four identifiers, all three kinds and both alignment verdicts. They do this against table contents that include overlapping tags, global entries and clean or invalid halves.

// File: rtl/tlbx_pkg.sv
// Shared encodings for the translation buffer.
// Assumes: callers use only the codes listed here on req_kind.
package tlbx_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_ADDR_RD = 3'd1,
        FLT_ADDR_WR = 3'd2,
        FLT_REFILL  = 3'd3,
        FLT_INVALID = 3'd4,
        FLT_MODIFY  = 3'd5
    } fault_e;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

endpackage

// File: rtl/tlbx_entry_store.sv
// Entry storage: N page-pair entries loaded whole through one write port.
// Assumes: wr_idx < N; reset clears every field, so all halves start invalid.
module tlbx_entry_store #(
    parameter int N      = 4,
    parameter int TAG_W  = 19,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_valid_even,
    input  logic              wr_dirty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_valid_odd,
    input  logic              wr_dirty_odd,
    output logic [TAG_W-1:0]  tag_q      [N],
    output logic [ASID_W-1:0] asid_q     [N],
    output logic [N-1:0]      glob_q,
    output logic [PFN_W-1:0]  pfn_even_q [N],
    output logic [PFN_W-1:0]  pfn_odd_q  [N],
    output logic [N-1:0]      v_even_q,
    output logic [N-1:0]      v_odd_q,
    output logic [N-1:0]      d_even_q,
    output logic [N-1:0]      d_odd_q
);

    // Clear on reset, otherwise overwrite the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                tag_q[i]      <= '0;
                asid_q[i]     <= '0;
                pfn_even_q[i] <= '0;
                pfn_odd_q[i]  <= '0;
            end
            glob_q   <= '0;
            v_even_q <= '0;
            v_odd_q  <= '0;
            d_even_q <= '0;
            d_odd_q  <= '0;
        end else if (wr_en) begin
            tag_q[wr_idx]      <= wr_tag;
            asid_q[wr_idx]     <= wr_asid;
            glob_q[wr_idx]     <= wr_global;
            pfn_even_q[wr_idx] <= wr_pfn_even;
            pfn_odd_q[wr_idx]  <= wr_pfn_odd;
            v_even_q[wr_idx]   <= wr_valid_even;
            v_odd_q[wr_idx]    <= wr_valid_odd;
            d_even_q[wr_idx]   <= wr_dirty_even;
            d_odd_q[wr_idx]    <= wr_dirty_odd;
        end
    end

endmodule

// File: rtl/tlbx_match.sv
// Parallel tag/identifier compare and lowest-index select of the matched half.
// Assumes: several matches may occur; the lowest index wins.
module tlbx_match #(
    parameter int N      = 4,
    parameter int TAG_W  = 19,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20
) (
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_odd,
    input  logic [TAG_W-1:0]  tag_q      [N],
    input  logic [ASID_W-1:0] asid_q     [N],
    input  logic [N-1:0]      glob_q,
    input  logic [PFN_W-1:0]  pfn_even_q [N],
    input  logic [PFN_W-1:0]  pfn_odd_q  [N],
    input  logic [N-1:0]      v_even_q,
    input  logic [N-1:0]      v_odd_q,
    input  logic [N-1:0]      d_even_q,
    input  logic [N-1:0]      d_odd_q,
    output logic              hit,
    output logic [PFN_W-1:0]  sel_pfn,
    output logic              sel_valid,
    output logic              sel_dirty
);

    logic [N-1:0] match;

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = (tag_q[g] == req_tag) &&
                          (glob_q[g] || (asid_q[g] == req_asid));
    end

    // Walk from the top so the lowest matching index is assigned last.
    always_comb begin
        hit       = 1'b0;
        sel_pfn   = '0;
        sel_valid = 1'b0;
        sel_dirty = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                sel_pfn   = req_odd ? pfn_odd_q[i] : pfn_even_q[i];
                sel_valid = req_odd ? v_odd_q[i]   : v_even_q[i];
                sel_dirty = req_odd ? d_odd_q[i]   : d_even_q[i];
            end
        end
    end

endmodule

// File: rtl/tlbx_classify.sv
// Fault priority (address error, refill, invalid, modify) and handler fill fields.
// Assumes: hit/valid/dirty/pfn describe the selected half for this request.
module tlbx_classify
    import tlbx_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int ASID_W    = 8,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int FILL_W   = VPN_W - 2
) (
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  logic [1:0]        kind,
    input  logic              misalign,
    input  logic              hit,
    input  logic [PFN_W-1:0]  pfn,
    input  logic              valid,
    input  logic              dirty,
    output fault_e            fault,
    output logic [PA_W-1:0]   pa,
    output logic [VA_W-1:0]   badvaddr,
    output logic [FILL_W-1:0] hi_vpn2,
    output logic [1:0]        hi_vpn2x,
    output logic [ASID_W-1:0] hi_asid,
    output logic [FILL_W-1:0] ctx_badvpn2
);

    logic [VPN_W-1:0] vpn;
    logic             is_store;
    logic             tlb_flt;

    assign vpn      = va[VA_W-1:PAGE_BITS];
    assign is_store = (kind == ACC_STORE);

    // Pick the highest-priority fault.
    always_comb begin
        fault = FLT_NONE;
        if (misalign)
            fault = is_store ? FLT_ADDR_WR : FLT_ADDR_RD;
        else if (!hit)
            fault = FLT_REFILL;
        else if (!valid)
            fault = FLT_INVALID;
        else if (is_store && !dirty)
            fault = FLT_MODIFY;
    end

    assign tlb_flt = (fault == FLT_REFILL) || (fault == FLT_INVALID) ||
                     (fault == FLT_MODIFY);

    // Result address and handler fill values, zero when they do not apply.
    always_comb begin
        pa          = (fault == FLT_NONE) ? {pfn, va[PAGE_BITS-1:0]} : '0;
        badvaddr    = (fault != FLT_NONE) ? va : '0;
        hi_vpn2     = tlb_flt ? vpn[VPN_W-1:2] : '0;
        hi_vpn2x    = tlb_flt ? vpn[1:0] : 2'b00;
        hi_asid     = tlb_flt ? asid : '0;
        ctx_badvpn2 = tlb_flt ? vpn[VPN_W-1:2] : '0;
    end

endmodule

// File: rtl/tlbx_top.sv
// Translation buffer top: storage, lookup, classification, one output register.
// Assumes: req_kind uses only fetch/load/store codes; misalign is valid with req_valid.
module tlbx_top
    import tlbx_pkg::*;
#(
    parameter int N         = 4,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int ASID_W    = 8,
    parameter int PAGE_BITS = 12,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int TAG_W    = VPN_W - 1,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int FILL_W   = VPN_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_valid_even,
    input  logic              wr_dirty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_valid_odd,
    input  logic              wr_dirty_odd,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [1:0]        req_kind,
    input  logic              req_misalign,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [VA_W-1:0]   rsp_badvaddr,
    output logic [FILL_W-1:0] rsp_hi_vpn2,
    output logic [1:0]        rsp_hi_vpn2x,
    output logic [ASID_W-1:0] rsp_hi_asid,
    output logic [FILL_W-1:0] rsp_ctx_badvpn2
);

    logic [TAG_W-1:0]  tag_q      [N];
    logic [ASID_W-1:0] asid_q     [N];
    logic [PFN_W-1:0]  pfn_even_q [N];
    logic [PFN_W-1:0]  pfn_odd_q  [N];
    logic [N-1:0]      glob_q, v_even_q, v_odd_q, d_even_q, d_odd_q;

    logic              hit, sel_valid, sel_dirty;
    logic [PFN_W-1:0]  sel_pfn;
    fault_e            c_fault;
    logic [PA_W-1:0]   c_pa;
    logic [VA_W-1:0]   c_bad;
    logic [FILL_W-1:0] c_vpn2, c_ctx;
    logic [1:0]        c_vpn2x;
    logic [ASID_W-1:0] c_asid;

    tlbx_entry_store #(.N(N), .TAG_W(TAG_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd),
        .tag_q(tag_q), .asid_q(asid_q), .glob_q(glob_q),
        .pfn_even_q(pfn_even_q), .pfn_odd_q(pfn_odd_q),
        .v_even_q(v_even_q), .v_odd_q(v_odd_q), .d_even_q(d_even_q), .d_odd_q(d_odd_q)
    );

    tlbx_match #(.N(N), .TAG_W(TAG_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_match (
        .req_tag(req_va[VA_W-1:PAGE_BITS+1]), .req_asid(req_asid), .req_odd(req_va[PAGE_BITS]),
        .tag_q(tag_q), .asid_q(asid_q), .glob_q(glob_q),
        .pfn_even_q(pfn_even_q), .pfn_odd_q(pfn_odd_q),
        .v_even_q(v_even_q), .v_odd_q(v_odd_q), .d_even_q(d_even_q), .d_odd_q(d_odd_q),
        .hit(hit), .sel_pfn(sel_pfn), .sel_valid(sel_valid), .sel_dirty(sel_dirty)
    );

    tlbx_classify #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .PAGE_BITS(PAGE_BITS)) u_class (
        .va(req_va), .asid(req_asid), .kind(req_kind), .misalign(req_misalign),
        .hit(hit), .pfn(sel_pfn), .valid(sel_valid), .dirty(sel_dirty),
        .fault(c_fault), .pa(c_pa), .badvaddr(c_bad),
        .hi_vpn2(c_vpn2), .hi_vpn2x(c_vpn2x), .hi_asid(c_asid), .ctx_badvpn2(c_ctx)
    );

    // Register the result of each request; hold it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_fault       <= FLT_NONE;
            rsp_pa          <= '0;
            rsp_badvaddr    <= '0;
            rsp_hi_vpn2     <= '0;
            rsp_hi_vpn2x    <= '0;
            rsp_hi_asid     <= '0;
            rsp_ctx_badvpn2 <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault       <= c_fault;
                rsp_pa          <= c_pa;
                rsp_badvaddr    <= c_bad;
                rsp_hi_vpn2     <= c_vpn2;
                rsp_hi_vpn2x    <= c_vpn2x;
                rsp_hi_asid     <= c_asid;
                rsp_ctx_badvpn2 <= c_ctx;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_MISALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_misalign |=> (rsp_fault == FLT_ADDR_RD || rsp_fault == FLT_ADDR_WR)); // R2
    AST_STORE_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_misalign && req_kind == ACC_STORE |=> rsp_fault == FLT_ADDR_WR); // R2
    AST_ALIGNED_NO_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_misalign |=> (rsp_fault != FLT_ADDR_RD && rsp_fault != FLT_ADDR_WR)); // R2
    AST_MODIFY_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind != ACC_STORE |=> rsp_fault != FLT_MODIFY); // R6
    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault != FLT_NONE ||
                       rsp_pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0]))); // R7
    AST_BADVADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault == FLT_NONE || rsp_badvaddr == $past(req_va))); // R8
    AST_FILL_ASID: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault < FLT_REFILL || rsp_hi_asid == $past(req_asid))); // R9

endmodule

// File: tb/tlbx_top_bench.sv
module tlbx_top_bench;

    localparam int N = 4, VA_W = 32, PA_W = 32, ASID_W = 8, PB = 12;
    localparam int VPN_W = VA_W - PB, TAG_W = VPN_W - 1, PFN_W = PA_W - PB, FILL_W = VPN_W - 2;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0;
    logic [1:0] wr_idx = 0;
    logic [TAG_W-1:0] wr_tag = 0;
    logic [ASID_W-1:0] wr_asid = 0;
    logic wr_global = 0;
    logic [PFN_W-1:0] wr_pfn_even = 0, wr_pfn_odd = 0;
    logic wr_valid_even = 0, wr_dirty_even = 0, wr_valid_odd = 0, wr_dirty_odd = 0;
    logic req_valid = 0;
    logic [VA_W-1:0] req_va = 0;
    logic [ASID_W-1:0] req_asid = 0;
    logic [1:0] req_kind = 0;
    logic req_misalign = 0;
    logic rsp_valid;
    logic [2:0] rsp_fault;
    logic [PA_W-1:0] rsp_pa;
    logic [VA_W-1:0] rsp_badvaddr;
    logic [FILL_W-1:0] rsp_hi_vpn2, rsp_ctx_badvpn2;
    logic [1:0] rsp_hi_vpn2x;
    logic [ASID_W-1:0] rsp_hi_asid;

    int checks = 0, errors = 0;

    // reference table, updated only from the bench's own writes
    logic [TAG_W-1:0] m_tag [N];
    logic [ASID_W-1:0] m_asid [N];
    logic m_g [N];
    logic [PFN_W-1:0] m_pfn [N][2];
    logic m_v [N][2];
    logic m_d [N][2];

    always #5 clk = ~clk;

    tlbx_top u_tlbx_top (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < N; i++) begin
            m_tag[i] = 0; m_asid[i] = 0; m_g[i] = 0;
            for (int h = 0; h < 2; h++) begin m_pfn[i][h] = 0; m_v[i][h] = 0; m_d[i][h] = 0; end
        end
    endtask

    task automatic wr(input int idx, input logic [TAG_W-1:0] tag, input logic [ASID_W-1:0] asid,
                      input logic g, input logic [PFN_W-1:0] pe, input logic ve, input logic de,
                      input logic [PFN_W-1:0] po, input logic vo, input logic dd);
        wr_en = 1; wr_idx = idx[1:0]; wr_tag = tag; wr_asid = asid; wr_global = g;
        wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dd;
        m_tag[idx] = tag; m_asid[idx] = asid; m_g[idx] = g;
        m_pfn[idx][0] = pe; m_v[idx][0] = ve; m_d[idx][0] = de;
        m_pfn[idx][1] = po; m_v[idx][1] = vo; m_d[idx][1] = dd;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Issue one request at a falling edge, compare after the next rising edge.
    task automatic req(input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid,
                       input logic [1:0] kind, input logic mis, input string force_tag);
        logic [VPN_W-1:0] vpn;
        int hit_i, e_code;
        logic [PA_W-1:0] e_pa;
        logic h;
        string t;
        vpn = va[VA_W-1:PB];
        h = vpn[0];
        hit_i = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_tag[i] == vpn[VPN_W-1:1] && (m_g[i] || m_asid[i] == asid)) hit_i = i;
        e_pa = 0;
        if (mis) e_code = (kind == 2) ? 2 : 1;
        else if (hit_i < 0) e_code = 3;
        else if (!m_v[hit_i][h]) e_code = 4;
        else if (kind == 2 && !m_d[hit_i][h]) e_code = 5;
        else begin e_code = 0; e_pa = {m_pfn[hit_i][h], va[PB-1:0]}; end
        case (e_code)
            0: t = "R7"; 1, 2: t = "R2"; 3: t = "R3"; 4: t = "R5"; default: t = "R6";
        endcase
        if (force_tag != "") t = force_tag;
        req_valid = 1; req_va = va; req_asid = asid; req_kind = kind; req_misalign = mis;
        @(negedge clk);
        req_valid = 0;
        chk("R1 rsp_valid", rsp_valid, 1);
        chk({t, " fault"}, rsp_fault, e_code);
        chk({t, " pa"}, rsp_pa, e_pa);
        chk("R8 badvaddr", rsp_badvaddr, (e_code != 0) ? va : 0);
        if (e_code >= 3) begin
            chk("R9 vpn2", rsp_hi_vpn2, vpn[VPN_W-1:2]);
            chk("R9 vpn2x", rsp_hi_vpn2x, vpn[1:0]);
            chk("R9 asid", rsp_hi_asid, asid);
            chk("R9 ctx", rsp_ctx_badvpn2, vpn[VPN_W-1:2]);
        end else begin
            chk("R9 zero fill", {rsp_hi_vpn2, rsp_hi_vpn2x, rsp_hi_asid, rsp_ctx_badvpn2}, 0);
        end
    endtask

    // Walk 8 pages x 4 identifiers x 3 kinds x both alignments.
    task automatic sweep(input logic [VPN_W-4:0] hi);
        for (int k = 0; k < 8; k++)
            for (int a = 0; a < 4; a++)
                for (int kd = 0; kd < 3; kd++)
                    for (int m = 0; m < 2; m++)
                        req({hi, k[2:0], 12'((k * 397 + a * 113 + kd * 29 + m) & 12'hFFF)},
                            a[7:0], kd[1:0], m[0], "");
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", rsp_valid, 0);
        chk("R1 reset fault", rsp_fault, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle rsp_valid", rsp_valid, 0);

        // R10: reset contents, all-zero tags and invalid halves
        sweep('0);
        req(32'h0000_0ABC, 8'd0, 2'd1, 1'b0, "R10");
        req(32'h0000_1ABC, 8'd5, 2'd1, 1'b0, "R10");

        // Config A: distinct tags, mixed valid/dirty, one global entry
        wr(0, {17'h1A5, 2'd0}, 8'd1, 0, 20'hAAA01, 1, 1, 20'hAAA02, 1, 0);
        wr(1, {17'h1A5, 2'd1}, 8'd2, 0, 20'hBBB01, 0, 0, 20'hBBB02, 1, 1);
        wr(2, {17'h1A5, 2'd2}, 8'd0, 1, 20'hCCC01, 1, 0, 20'hCCC02, 0, 1);
        wr(3, {17'h1A5, 2'd3}, 8'd3, 0, 20'hDDD01, 1, 1, 20'hDDD02, 1, 1);
        sweep(17'h1A5);
        req({17'h1A5, 3'd0, 12'h123}, 8'd1, 2'd1, 1'b0, "R4");
        req({17'h1A5, 3'd0, 12'h123}, 8'd2, 2'd1, 1'b0, "R4");
        req({17'h1A5, 3'd5, 12'h456}, 8'hEE, 2'd0, 1'b0, "R4");
        req({17'h1A5, 3'd1, 12'h010}, 8'd1, 2'd2, 1'b0, "R6");
        req({17'h1A5, 3'd1, 12'h010}, 8'd1, 2'd1, 1'b0, "R6");

        // Config B: overlapping matches, lowest index must win
        wr(0, {17'h0F0F, 2'd1}, 8'd1, 0, 20'h11111, 0, 0, 20'h11112, 1, 0);
        wr(1, {17'h0F0F, 2'd1}, 8'd0, 1, 20'h22221, 1, 1, 20'h22222, 1, 1);
        wr(2, {17'h0F0F, 2'd0}, 8'd0, 0, 20'h33331, 1, 0, 20'h33332, 1, 1);
        wr(3, {17'h0F0F, 2'd0}, 8'd0, 0, 20'h44441, 1, 1, 20'h44442, 0, 0);
        sweep(17'h0F0F);
        req({17'h0F0F, 3'd2, 12'h0F0}, 8'd1, 2'd1, 1'b0, "R11");
        req({17'h0F0F, 3'd2, 12'h0F0}, 8'd3, 2'd1, 1'b0, "R11");
        req({17'h0F0F, 3'd1, 12'h777}, 8'd0, 2'd0, 1'b0, "R11");

        // R10: a write is visible to the request in the next cycle
        wr(2, {17'h0F0F, 2'd0}, 8'd0, 0, 20'h55551, 1, 1, 20'h55552, 1, 1);
        req({17'h0F0F, 3'd0, 12'h321}, 8'd0, 2'd2, 1'b0, "R10");
        @(negedge clk);
        chk("R1 idle after request", rsp_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule